// File: doc/BRIEF.md
# Reset Sequencer with Cause Register

This block merges four reset requests into one active-low reset output and keeps a record of which request started the most recent reset. The requests are a supply-failure indication (power-on and low-voltage folded into a single source, presented as an active-high `pwr_good_i` that is low while the supply is not usable), a watchdog expiry, a system trap and a software reset request. All four may change asynchronously to `clk_i` and each passes through a two-flop synchronizer before it is used.

While any synchronized request is active the reset output is held low. After the last request goes away, the output stays low for a further `STRETCH_CYCLES` clock cycles (default 16) and is then released. The cause register is reset only by `rst_ni`, the block's own power-on reset, and not by `rst_no`. Because of this, software that runs after a watchdog, trap or software reset can read back what happened through a one-cycle read port.

Top module: `reset_sequencer`

## Requirements
- R1: While `rst_ni` is low, `rst_no` is low. After `rst_ni` rises, `rst_no` stays low while `pwr_good_i` is low, and for the stretch period after the synchronized supply-good is seen.
- R2: A request seen at a rising edge reaches `rst_no` three edges later: two synchronizer stages and one sequencing register.
- R3: `rst_no` is low in every cycle that follows a cycle with any synchronized request active.
- R4: Once the synchronized requests have all cleared, `rst_no` stays low for exactly `STRETCH_CYCLES` more edges and then goes high. Counted from the input edge where the last raw request is seen low, it is still low after `STRETCH_CYCLES`+1 edges and high after `STRETCH_CYCLES`+2 edges.
- R5: The cause value always has exactly one bit set. Bit 0 means supply failure, bit 1 watchdog, bit 2 trap and bit 3 software request.
- R6: A synchronized supply failure writes cause 4'b0001 at any time, including in the middle of a reset started by another source.
- R7: A watchdog, trap or software request writes its cause code only on the edge where a reset episode begins (`rst_no` high). Requests that arrive while `rst_no` is low leave the cause unchanged.
- R8: When several requests start an episode on the same edge, the cause is the single highest-priority one. The priority order is supply, then watchdog, then trap, then software.
- R9: The cause written by a watchdog, trap or software reset stays readable after `rst_no` has been released.
- R10: If `rd_en_i` is high at an edge, `rd_data_o` holds the cause value from before that edge. If `rd_en_i` is low, `rd_data_o` is 4'b0000.
- R11: After `rst_ni`, the cause reads 4'b0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the block itself |
| pwr_good_i | input | 1 | Supply usable; low means power-up or low-voltage condition |
| wdt_expire_i | input | 1 | Watchdog expiry request |
| trap_i | input | 1 | System trap reset request |
| sw_rst_i | input | 1 | Software reset request |
| rd_en_i | input | 1 | Read strobe for the cause register |
| rd_data_o | output | 4 | Registered cause read data, one-hot |
| rst_no | output | 1 | Chip reset, active low |

## Verification
The stretch length is measured edge by edge after each release. If the counter reloads late, or if release is judged from the raw inputs instead of the synchronized ones, the reset is released one cycle early or one cycle late.

Several requests are raised on the same edge to check the cause priority. If the priority is reversed, the register records the software or trap code instead of the watchdog code.

A second request is raised while a reset is already running. A design that records on every request would overwrite the cause. A design that gates supply failure like the other sources would miss a brownout that happens during a watchdog reset.

Reads are taken after release, which exposes a cause register that was wrongly cleared by its own reset output.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  localparam int unsigned SRC_N = 4;
  typedef enum int unsigned {
    SRC_PWR  = 0,
    SRC_WDT  = 1,
    SRC_TRAP = 2,
    SRC_SW   = 3
  } src_idx_e;
  typedef logic [SRC_N-1:0] src_vec_t;
  localparam src_vec_t CAUSE_PWR = src_vec_t'(1) << SRC_PWR;
endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/rstseq_prio.sv
module rstseq_prio #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] req_i,
  output logic [W-1:0] grant_o
);
  // lowest index wins
  always_comb begin
    grant_o = '0;
    for (int i = int'(W) - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rstseq_stretch.sv
module rstseq_stretch #(
  parameter int unsigned STRETCH = 16,
  localparam int unsigned CNT_W  = $clog2(STRETCH + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  output logic active_o
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(STRETCH);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= LOAD;
      act_q <= 1'b1;
    end else if (hold_i) begin
      cnt_q <= LOAD;
      act_q <= 1'b1;
    end else if (cnt_q > ONE) begin
      cnt_q <= cnt_q - ONE;
    end else if (cnt_q == ONE) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end
  end

  assign active_o = act_q;
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
  import rstseq_pkg::*;
#(
  parameter int unsigned STRETCH_CYCLES = 16,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_good_i,
  input  logic             wdt_expire_i,
  input  logic             trap_i,
  input  logic             sw_rst_i,
  input  logic             rd_en_i,
  output logic [SRC_N-1:0] rd_data_o,
  output logic             rst_no
);
  src_vec_t req_raw, req_sync, req_grant, cause_q;
  logic     rst_act;

  always_comb begin
    req_raw           = '0;
    req_raw[SRC_PWR]  = ~pwr_good_i;
    req_raw[SRC_WDT]  = wdt_expire_i;
    req_raw[SRC_TRAP] = trap_i;
    req_raw[SRC_SW]   = sw_rst_i;
  end

  rstseq_sync #(
    .W      (SRC_N),
    .STAGES (SYNC_STAGES),
    .RST_VAL(CAUSE_PWR)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_raw),
    .q_o   (req_sync)
  );

  rstseq_prio #(.W(SRC_N)) u_prio (
    .req_i  (req_sync),
    .grant_o(req_grant)
  );

  rstseq_stretch #(.STRETCH(STRETCH_CYCLES)) u_stretch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hold_i  (|req_sync),
    .active_o(rst_act)
  );

  // supply failure always overwrites; other sources only open an episode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= CAUSE_PWR;
    end else if (req_sync[SRC_PWR]) begin
      cause_q <= CAUSE_PWR;
    end else if (!rst_act && (|req_sync)) begin
      cause_q <= req_grant;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_data_o <= '0;
    else         rd_data_o <= rd_en_i ? cause_q : '0;
  end

  assign rst_no = ~rst_act;
endmodule

// File: rtl/rstseq_checker.sv
module rstseq_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [3:0] req_s,
  input logic [3:0] cause,
  input logic       rst_no,
  input logic       rd_en_i,
  input logic [3:0] rd_data_o
);
  AST_CAUSE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(cause) == 1); // R5

  AST_REQ_HOLDS_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_s != 4'b0000) |=> !rst_no); // R3

  AST_PWR_OVERWRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_s[0] |=> (cause == 4'b0001)); // R6

  AST_NO_RECAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rst_no && !req_s[0]) |=> $stable(cause)); // R7

  AST_RELEASE_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_no) |-> ($past(req_s) == 4'b0000)); // R4

  AST_RD_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> (rd_data_o == $past(cause))); // R10
endmodule

bind reset_sequencer rstseq_checker u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_s    (req_sync),
  .cause    (cause_q),
  .rst_no   (rst_no),
  .rd_en_i  (rd_en_i),
  .rd_data_o(rd_data_o)
);

// File: tb/tb_reset_sequencer.sv
module tb_reset_sequencer;
  localparam int STRETCH = 16;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pwr_good_i = 1'b0;
  logic       wdt_expire_i = 1'b0;
  logic       trap_i = 1'b0;
  logic       sw_rst_i = 1'b0;
  logic       rd_en_i = 1'b0;
  logic [3:0] rd_data_o;
  logic       rst_no;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i; // 125 MHz

  reset_sequencer #(.STRETCH_CYCLES(STRETCH)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwr_good_i(pwr_good_i),
    .wdt_expire_i(wdt_expire_i), .trap_i(trap_i), .sw_rst_i(sw_rst_i),
    .rd_en_i(rd_en_i), .rd_data_o(rd_data_o), .rst_no(rst_no)
  );

  // behavioural reference: delay line of raw requests, a countdown, a cause code
  logic [3:0] m_pipe [$];
  int         m_cnt = STRETCH;
  bit         m_rst = 1'b1;
  logic [3:0] m_cause = 4'b0001;
  logic [3:0] m_rd = 4'b0000;

  function automatic logic [3:0] pick(input logic [3:0] r);
    if (r[0]) return 4'b0001;
    if (r[1]) return 4'b0010;
    if (r[2]) return 4'b0100;
    if (r[3]) return 4'b1000;
    return 4'b0000;
  endfunction

  always @(posedge clk_i) begin
    logic [3:0] seen;
    logic [3:0] raw;
    if (!rst_ni) begin
      m_pipe.delete();
      m_pipe.push_back(4'b0001);
      m_pipe.push_back(4'b0001);
      m_cnt   = STRETCH;
      m_rst   = 1'b1;
      m_cause = 4'b0001;
      m_rd    = 4'b0000;
    end else begin
      seen = m_pipe[0];
      raw  = {sw_rst_i, trap_i, wdt_expire_i, ~pwr_good_i};
      m_rd = rd_en_i ? m_cause : 4'b0000;
      if (seen[0]) m_cause = 4'b0001;
      else if (!m_rst && seen != 4'b0000) m_cause = pick(seen);
      if (seen != 4'b0000) begin
        m_cnt = STRETCH;
        m_rst = 1'b1;
      end else if (m_cnt > 1) begin
        m_cnt = m_cnt - 1;
      end else if (m_cnt == 1) begin
        m_cnt = 0;
        m_rst = 1'b0;
      end
      void'(m_pipe.pop_front());
      m_pipe.push_back(raw);
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      n_run++;
      if (rst_no !== !m_rst) begin
        n_fail++;
        $display("FAIL R4 rst_no per-cycle: actual %b expected %b", rst_no, !m_rst);
      end
      n_run++;
      if (rd_data_o !== m_rd) begin
        n_fail++;
        $display("FAIL R10 rd_data per-cycle: actual %b expected %b", rd_data_o, m_rd);
      end
    end
  end

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic read_cause(input string tag, input logic [3:0] exp);
    @(negedge clk_i);
    rd_en_i = 1'b1;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    chk(tag, rd_data_o, exp);
  endtask

  task automatic wait_release();
    for (int i = 0; i < 200 && !rst_no; i++) @(negedge clk_i);
  endtask

  initial begin
    ticks(3);
    chk("R1 rst_no low during rst_ni", {3'b0, rst_no}, 4'b0000);
    rst_ni = 1'b1;
    ticks(2);
    read_cause("R11 cause after rst_ni", 4'b0001);
    ticks(10);
    chk("R1 held while supply bad", {3'b0, rst_no}, 4'b0000);
    // supply good: release after stretch
    pwr_good_i = 1'b1;
    ticks(STRETCH + 1);
    chk("R1 still low before stretch end", {3'b0, rst_no}, 4'b0000);
    ticks(1);
    chk("R1 released after stretch", {3'b0, rst_no}, 4'b0001);
    chk("R10 idle read is zero", rd_data_o, 4'b0000);

    // software request: latency and stretch
    sw_rst_i = 1'b1;
    ticks(2);
    chk("R2 not yet asserted after 2 edges", {3'b0, rst_no}, 4'b0001);
    ticks(1);
    chk("R2 asserted after 3 edges", {3'b0, rst_no}, 4'b0000);
    ticks(5);
    sw_rst_i = 1'b0;
    ticks(STRETCH + 1);
    chk("R4 low at stretch+1", {3'b0, rst_no}, 4'b0000);
    ticks(1);
    chk("R4 high at stretch+2", {3'b0, rst_no}, 4'b0001);
    read_cause("R9 software cause kept", 4'b1000);

    // same-edge requests
    @(negedge clk_i);
    wdt_expire_i = 1'b1; trap_i = 1'b1; sw_rst_i = 1'b1;
    ticks(4);
    wdt_expire_i = 1'b0; trap_i = 1'b0; sw_rst_i = 1'b0;
    wait_release();
    read_cause("R8 priority watchdog over trap/sw", 4'b0010);

    @(negedge clk_i);
    trap_i = 1'b1; sw_rst_i = 1'b1;
    ticks(4);
    trap_i = 1'b0; sw_rst_i = 1'b0;
    wait_release();
    read_cause("R8 priority trap over sw", 4'b0100);

    // later request during an episode is not recorded
    @(negedge clk_i);
    sw_rst_i = 1'b1;
    ticks(4);
    sw_rst_i = 1'b0;
    ticks(3);
    wdt_expire_i = 1'b1;
    ticks(4);
    wdt_expire_i = 1'b0;
    read_cause("R7 cause frozen in episode", 4'b1000);
    wait_release();
    read_cause("R7 cause after release", 4'b1000);

    // brownout during a watchdog reset overwrites
    @(negedge clk_i);
    wdt_expire_i = 1'b1;
    ticks(4);
    read_cause("R9 watchdog cause", 4'b0010);
    pwr_good_i = 1'b0;
    ticks(4);
    read_cause("R6 supply overwrites mid-episode", 4'b0001);
    wdt_expire_i = 1'b0;
    pwr_good_i = 1'b1;
    wait_release();
    read_cause("R5 one-hot supply code", 4'b0001);
    chk("R3 released only after all clear", {3'b0, rst_no}, 4'b0001);

    ticks(3);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule